// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block drives a 10-bit successive-approximation converter. Software settings arrive as plain input levels: an enable, a 3-bit channel choice, a 3-bit clock divider choice, a free-running flag and a one-cycle start write. A prescaler slows the system clock down to a converter clock. For each converter cycle the sequencer presents a trial code to an external DAC and comparator. It reads back a single compare bit and, one bit at a time from the most significant end, settles the code that matches the selected input.

A conversion takes twelve converter clocks: one to sample and latch the channel, ten bit trials, and one to complete. The completion cycle moves the code to the result output and raises a one-system-clock done pulse. The start bit reads high for the whole conversion and clears itself at the end. In free-running mode the next conversion starts straight after the completion cycle and the start bit stays high. Clearing the enable stops any conversion, holds the prescaler in reset and freezes the applied channel.

Top module: `adc_sar_seq`

## Requirements
- R1: After reset, busy_o, done_o, result_o, trial_code_o and chan_o are all zero.
- R2: The result equals the input level of the latched channel. The comparator model returns 1 when that input is at least trial_code_o. Codes 0 and 1023 are reachable.
- R3: A compare bit of 1 keeps the bit under trial and 0 clears it. A comparator stuck at 1 yields 1023 and one stuck at 0 yields 0.
- R4: A start write with the enable high sets busy_o from the next cycle. In single mode busy_o falls in the same cycle that done_o is high.
- R5: done_o is high for exactly one system clock per completed result.
- R6: chan_o takes chan_sel_i only when a conversion begins. A change during a conversion leaves that result on the old channel and applies to the next conversion.
- R7: In free-running mode conversions follow back to back, busy_o stays high, and the result keeps updating.
- R8: presc_sel_i codes 0 to 7 divide by 2, 2, 4, 8, 16, 32, 64 and 128. Successive free-running done pulses are 12 times the divisor apart.
- R9: With the enable low, busy_o is low, start writes are ignored, no done pulse occurs, and chan_o holds its value.
- R10: In single mode no further conversion or done pulse follows a completed one without a new start write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Converter enable; low aborts and holds the prescaler reset |
| start_i | input | 1 | One-cycle write of 1 to the start bit |
| free_run_i | input | 1 | 1 selects free-running, 0 selects single conversion |
| chan_sel_i | input | 3 | Requested input channel |
| presc_sel_i | input | 3 | Prescaler tap choice |
| cmp_i | input | 1 | Comparator: 1 when input is at least the trial code |
| busy_o | output | 1 | Start bit readback, high while converting |
| trial_code_o | output | 10 | Code driven to the DAC |
| chan_o | output | 3 | Channel applied to the input multiplexer |
| result_o | output | 10 | Last completed result |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench feeds the extreme codes 0 and 1023 and the alternating and half-scale codes. A design with an inverted compare sense or a trial order that starts at the wrong end gives a different result for these. It moves the channel choice in the middle of a conversion, which catches a design that switches the multiplexer at once and returns a blend of two inputs. It times the gap between free-running done pulses for the shortest, a middle and the longest divisor, which exposes a wrong tap or a conversion that is a cycle short. It also drops the enable during a conversion, which catches a start bit that stays stuck high or a prescaler that keeps running.

// File: rtl/adc_sar_pkg.sv
package adc_sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SAMP  = 2'd1,
    ST_TRIAL = 2'd2,
    ST_DONE  = 2'd3
  } sar_state_e;
endpackage

// File: rtl/adc_presc.sv
module adc_presc #(
  parameter int unsigned PS_W  = 7,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [PS_W-1:0]  cnt_q;
  logic [PS_W-1:0]  mask;
  logic [SEL_W-1:0] shift;

  // code 0 shares the divide-by-2 tap with code 1
  assign shift = (sel_i == '0) ? SEL_W'(1) : sel_i;

  for (genvar i = 0; i < PS_W; i++) begin : g_mask
    assign mask[i] = (32'(shift) > i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && ((cnt_q & mask) == mask);
endmodule

// File: rtl/adc_start_ctl.sv
module adc_start_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic start_i,
  input  logic free_run_i,
  input  logic conv_end_i,
  output logic busy_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       busy_o <= 1'b0;
    else if (!en_i)                    busy_o <= 1'b0;
    else if (start_i)                  busy_o <= 1'b1;
    else if (conv_end_i && !free_run_i) busy_o <= 1'b0;
  end
endmodule

// File: rtl/adc_sar_fsm.sv
module adc_sar_fsm
  import adc_sar_pkg::*;
#(
  parameter int unsigned RES_W = 10,
  parameter int unsigned CH_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             go_i,
  input  logic             free_run_i,
  input  logic [CH_W-1:0]  chan_sel_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] trial_o,
  output logic [CH_W-1:0]  chan_o,
  output logic [RES_W-1:0] result_o,
  output logic             conv_end_o,
  output logic             done_o
);
  localparam int unsigned IDX_W = $clog2(RES_W);

  sar_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [RES_W-1:0] code_q, code_nxt;

  always_comb begin
    code_nxt = code_q;
    code_nxt[idx_q] = cmp_i;
    if (idx_q != '0) code_nxt[idx_q - 1'b1] = 1'b1;
  end

  assign conv_end_o = tick_i && (state_q == ST_DONE);
  assign trial_o    = code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      code_q   <= '0;
      chan_o   <= '0;
      result_o <= '0;
      done_o   <= 1'b0;
    end else if (!en_i) begin
      state_q <= ST_IDLE;
      code_q  <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= conv_end_o;
      if (tick_i) begin
        unique case (state_q)
          ST_IDLE: if (go_i) begin
            chan_o  <= chan_sel_i;
            state_q <= ST_SAMP;
          end
          ST_SAMP: begin
            code_q  <= RES_W'(1) << (RES_W - 1);
            idx_q   <= IDX_W'(RES_W - 1);
            state_q <= ST_TRIAL;
          end
          ST_TRIAL: begin
            code_q <= code_nxt;
            if (idx_q == '0) state_q <= ST_DONE;
            else             idx_q   <= idx_q - 1'b1;
          end
          ST_DONE: begin
            result_o <= code_q;
            code_q   <= '0;
            if (free_run_i && go_i) begin
              chan_o  <= chan_sel_i;
              state_q <= ST_SAMP;
            end else begin
              state_q <= ST_IDLE;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq #(
  parameter int unsigned RES_W = 10,
  parameter int unsigned CH_W  = 3,
  parameter int unsigned PS_W  = 7,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_i,
  input  logic             free_run_i,
  input  logic [CH_W-1:0]  chan_sel_i,
  input  logic [SEL_W-1:0] presc_sel_i,
  input  logic             cmp_i,
  output logic             busy_o,
  output logic [RES_W-1:0] trial_code_o,
  output logic [CH_W-1:0]  chan_o,
  output logic [RES_W-1:0] result_o,
  output logic             done_o
);
  logic tick, conv_end;

  adc_presc #(.PS_W(PS_W), .SEL_W(SEL_W)) i_presc (
    .clk_i, .rst_ni, .en_i, .sel_i(presc_sel_i), .tick_o(tick)
  );

  adc_start_ctl i_ctl (
    .clk_i, .rst_ni, .en_i, .start_i, .free_run_i,
    .conv_end_i(conv_end), .busy_o
  );

  adc_sar_fsm #(.RES_W(RES_W), .CH_W(CH_W)) i_fsm (
    .clk_i, .rst_ni, .en_i, .tick_i(tick), .go_i(busy_o), .free_run_i,
    .chan_sel_i, .cmp_i, .trial_o(trial_code_o), .chan_o,
    .result_o, .conv_end_o(conv_end), .done_o
  );
endmodule

// File: rtl/adc_sar_seq_chk.sv
module adc_sar_seq_chk #(
  parameter int unsigned CH_W = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            en_i,
  input logic            busy_o,
  input logic            done_o,
  input logic [CH_W-1:0] chan_o
);
  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r4_busy_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (done_o || !$past(en_i)));

  a_r9_off_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!busy_o && !done_o));

  a_r9_off_chan_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(chan_o));
endmodule

bind adc_sar_seq adc_sar_seq_chk #(.CH_W(CH_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
  .busy_o(busy_o), .done_o(done_o), .chan_o(chan_o)
);

// File: tb/test_adc_sar_seq.sv
module test_adc_sar_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0, start_i = 1'b0, free_run_i = 1'b0, cmp_i;
  logic [2:0] chan_sel_i = '0, presc_sel_i = '0;
  logic       busy_o, done_o;
  logic [9:0] trial_code_o, result_o;
  logic [2:0] chan_o;

  logic [9:0] vin [8];
  logic       force_en = 1'b0, force_val = 1'b0;
  int         n_chk = 0, n_bad = 0;

  always #5 clk_i = ~clk_i;

  assign cmp_i = force_en ? force_val : (vin[chan_o] >= trial_code_o);

  adc_sar_seq i_adc_sar_seq (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // wait for done_o at a negedge; returns cycles waited or -1
  task automatic wait_done(input int limit, output int cyc);
    cyc = -1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk_i);
      if (done_o) begin cyc = i; return; end
    end
  endtask

  task automatic pulse_start();
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
  endtask

  task automatic t_reset();
    chk(busy_o == 0 && done_o == 0, "R1 busy/done", {busy_o, done_o}, 0);
    chk(result_o == 0 && trial_code_o == 0, "R1 result/trial", result_o | trial_code_o, 0);
    chk(chan_o == 0, "R1 chan", chan_o, 0);
  endtask

  task automatic t_single(input int ch, input int val);
    int c;
    vin[ch] = 10'(val); chan_sel_i = 3'(ch);
    pulse_start();
    chk(busy_o == 1, "R4 busy after start", busy_o, 1);
    wait_done(200, c);
    chk(c > 0, "R5 done seen", c, 1);
    chk(result_o == 10'(val), "R2 result", result_o, val);
    chk(busy_o == 0, "R4 busy clears with done", busy_o, 0);
    chk(chan_o == 3'(ch), "R6 chan applied", chan_o, ch);
    @(negedge clk_i);
    chk(done_o == 0, "R5 done one cycle", done_o, 0);
  endtask

  task automatic t_forced(input bit v);
    int c;
    force_en = 1'b1; force_val = v;
    pulse_start();
    wait_done(200, c);
    chk(result_o == (v ? 10'h3FF : 10'h0), "R3 stuck comparator", result_o, v ? 1023 : 0);
    force_en = 1'b0;
  endtask

  task automatic t_defer();
    int c;
    vin[1] = 10'd100; vin[6] = 10'd900; chan_sel_i = 3'd1;
    pulse_start();
    repeat (10) @(negedge clk_i);
    chan_sel_i = 3'd6;
    wait_done(200, c);
    chk(result_o == 10'd100, "R6 old channel result", result_o, 100);
    chk(chan_o == 3'd1, "R6 chan held", chan_o, 1);
    pulse_start();
    wait_done(200, c);
    chk(result_o == 10'd900, "R6 new channel next", result_o, 900);
  endtask

  task automatic t_no_restart();
    int c;
    wait_done(150, c);
    chk(c == -1, "R10 no further done", c, -1);
    chk(busy_o == 0, "R10 busy low", busy_o, 0);
  endtask

  task automatic t_free(input int sel, input int div);
    int c;
    presc_sel_i = 3'(sel); free_run_i = 1'b1;
    chan_sel_i = 3'd3; vin[3] = 10'h2AA;
    pulse_start();
    wait_done(40 * div, c);
    chk(result_o == 10'h2AA, "R7 free-run result", result_o, 'h2AA);
    vin[3] = 10'h155;
    wait_done(20 * div, c);
    chk(c == 12 * div, "R8 done period", c, 12 * div);
    chk(busy_o == 1, "R7 busy stays high", busy_o, 1);
    chk(result_o == 10'h155, "R7 result updates", result_o, 'h155);
    @(negedge clk_i); en_i = 1'b0; free_run_i = 1'b0;
    @(negedge clk_i); en_i = 1'b1; presc_sel_i = '0;
  endtask

  task automatic t_disable();
    int c;
    chan_sel_i = 3'd2; vin[2] = 10'd7;
    pulse_start();
    repeat (8) @(negedge clk_i);
    en_i = 1'b0;
    @(negedge clk_i);
    chk(busy_o == 0, "R9 abort clears busy", busy_o, 0);
    chan_sel_i = 3'd5; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    chk(busy_o == 0, "R9 start ignored", busy_o, 0);
    wait_done(100, c);
    chk(c == -1, "R9 no done while off", c, -1);
    chk(chan_o == 3'd2, "R9 chan held", chan_o, 2);
    en_i = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    for (int i = 0; i < 8; i++) vin[i] = 10'(i * 37);
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    en_i = 1'b1;
    t_single(0, 0);
    t_single(7, 1023);
    t_single(4, 512);
    t_single(5, 511);
    t_single(2, 'h2AA);
    t_no_restart();
    t_forced(1'b1);
    t_forced(1'b0);
    t_defer();
    t_free(0, 2);
    t_free(3, 8);
    t_free(7, 128);
    t_disable();
    t_single(6, 321);
    summary();
  end
endmodule